// File: doc/BRIEF.md
# I/O Bypass and Memory Port Arbiter

This block sits between the core-facing ports of a multi-port cache and the one memory port behind it. Each core request flagged as I/O skips the cache and is sent straight to memory. Every other request is handed to the cache unchanged. The memory request port is shared between cache-bank miss traffic and this uncached traffic by a two-input, fixed-priority arbiter. Bank traffic always wins a same-cycle conflict.

Uncached responses are sent back to the right core port without any tracking storage. For an outgoing bypass request, the core tag is shifted left by log2 of the number of core ports, and the requesting port's index fills the vacated low bits. The most significant bit of the memory tag is a direction flag (1 = bypass, 0 = bank). When a response returns, the flag picks between the bank fill output and the core response outputs. For a bypass response, the low index bits pick the core port and the bits above them give back the original core tag.

The block is purely combinational. Every valid/ready handshake completes in the cycle its valid and ready are both high at a clock edge.

Top module: `io_bypass_arbiter`

## Requirements
- R1: A core request whose I/O flag is 0 shows on `cache_req_valid` for its port and takes its ready from `cache_req_ready`. It never reaches the memory port.
- R2: An I/O request from core port p with tag t produces a memory request with write, address and data passed through. Its memory tag is `{1'b1, t, p}`, where p takes log2(NUM_IN) bits, zero-extended below the flag. The request does not appear on `cache_req_valid`.
- R3: When the bank miss port and a bypass request are valid in the same cycle, the bank request is the one presented to memory. The I/O core port sees ready low.
- R4: When several core ports raise I/O requests together, the lowest-numbered port is served. All others see ready low.
- R5: A bank request with tag b is presented to memory with tag `{1'b0, b}`, and `bank_req_ready` follows `mem_req_ready`.
- R6: A memory response with tag bit MEM_TAG_W-1 set raises `core_rsp_valid` only for the port given by the low log2(NUM_IN) tag bits. That port receives the tag bits above the index and the response data. `mem_rsp_ready` follows that port's ready.
- R7: A memory response with tag bit MEM_TAG_W-1 clear goes to the bank fill output with the low BANK_TAG_W tag bits. No core response is raised, and `mem_rsp_ready` follows `bank_rsp_ready`.
- R8: While `mem_req_ready` is low, no I/O core request and no bank request is given ready.
- R9: At most one core response valid is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_req_valid | input | NUM_IN | Request valid per core port |
| core_req_io | input | NUM_IN | Uncached (I/O) flag per core port |
| core_req_write | input | NUM_IN | Write flag per core port |
| core_req_addr | input | NUM_IN*ADDR_W | Address per core port |
| core_req_data | input | NUM_IN*DATA_W | Write data per core port |
| core_req_tag | input | NUM_IN*CORE_TAG_W | Tag per core port |
| core_req_ready | output | NUM_IN | Request accepted per core port |
| cache_req_valid | output | NUM_IN | Cacheable request forwarded to the cache |
| cache_req_ready | input | NUM_IN | Cache accepts the forwarded request |
| bank_req_valid | input | 1 | Bank miss/writeback request valid |
| bank_req_write | input | 1 | Bank request write flag |
| bank_req_addr | input | ADDR_W | Bank request address |
| bank_req_data | input | DATA_W | Bank request data |
| bank_req_tag | input | BANK_TAG_W | Bank request tag |
| bank_req_ready | output | 1 | Bank request accepted |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_write | output | 1 | Memory request write flag |
| mem_req_addr | output | ADDR_W | Memory request address |
| mem_req_data | output | DATA_W | Memory request data |
| mem_req_tag | output | MEM_TAG_W | Memory tag: direction flag plus body |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | DATA_W | Memory response data |
| mem_rsp_tag | input | MEM_TAG_W | Memory response tag |
| mem_rsp_ready | output | 1 | Response consumed |
| bank_rsp_valid | output | 1 | Fill response valid to the banks |
| bank_rsp_data | output | DATA_W | Fill response data |
| bank_rsp_tag | output | BANK_TAG_W | Fill response tag |
| bank_rsp_ready | input | 1 | Banks accept the fill |
| core_rsp_valid | output | NUM_IN | Bypass response valid per core port |
| core_rsp_data | output | DATA_W | Bypass response data |
| core_rsp_tag | output | CORE_TAG_W | Restored core tag |
| core_rsp_ready | input | NUM_IN | Core port accepts the response |

## Verification
No register lies on any path, so every output settles in the same cycle its inputs change. A request or response counts as transferred at the next rising edge where valid and ready are both high. The bench changes inputs on the falling edge. It checks ready, valid and steering outputs one nanosecond later, while the inputs still hold. The scoreboard takes an expected memory request from its queue only at the rising edge where a transfer completes. This catches any request that is extra, missing or out of order.

// File: rtl/io_bypass_arbiter.sv
module io_bypass_arbiter #(
  parameter int NUM_IN     = 4,
  parameter int CORE_TAG_W = 6,
  parameter int BANK_TAG_W = 8,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  localparam int IDX_W     = $clog2(NUM_IN),
  localparam int BYP_TAG_W = CORE_TAG_W + IDX_W,
  localparam int BODY_W    = (BYP_TAG_W > BANK_TAG_W) ? BYP_TAG_W : BANK_TAG_W,
  localparam int MEM_TAG_W = BODY_W + 1
) (
  input  logic [NUM_IN-1:0]            core_req_valid,
  input  logic [NUM_IN-1:0]            core_req_io,
  input  logic [NUM_IN-1:0]            core_req_write,
  input  logic [NUM_IN*ADDR_W-1:0]     core_req_addr,
  input  logic [NUM_IN*DATA_W-1:0]     core_req_data,
  input  logic [NUM_IN*CORE_TAG_W-1:0] core_req_tag,
  output logic [NUM_IN-1:0]            core_req_ready,
  output logic [NUM_IN-1:0]            cache_req_valid,
  input  logic [NUM_IN-1:0]            cache_req_ready,
  input  logic                         bank_req_valid,
  input  logic                         bank_req_write,
  input  logic [ADDR_W-1:0]            bank_req_addr,
  input  logic [DATA_W-1:0]            bank_req_data,
  input  logic [BANK_TAG_W-1:0]        bank_req_tag,
  output logic                         bank_req_ready,
  output logic                         mem_req_valid,
  output logic                         mem_req_write,
  output logic [ADDR_W-1:0]            mem_req_addr,
  output logic [DATA_W-1:0]            mem_req_data,
  output logic [MEM_TAG_W-1:0]         mem_req_tag,
  input  logic                         mem_req_ready,
  input  logic                         mem_rsp_valid,
  input  logic [DATA_W-1:0]            mem_rsp_data,
  input  logic [MEM_TAG_W-1:0]         mem_rsp_tag,
  output logic                         mem_rsp_ready,
  output logic                         bank_rsp_valid,
  output logic [DATA_W-1:0]            bank_rsp_data,
  output logic [BANK_TAG_W-1:0]        bank_rsp_tag,
  input  logic                         bank_rsp_ready,
  output logic [NUM_IN-1:0]            core_rsp_valid,
  output logic [DATA_W-1:0]            core_rsp_data,
  output logic [CORE_TAG_W-1:0]        core_rsp_tag,
  input  logic [NUM_IN-1:0]            core_rsp_ready
);

  initial begin
    if (NUM_IN < 2 || (NUM_IN & (NUM_IN - 1)) != 0)
      $error("io_bypass_arbiter: NUM_IN must be a power of two of at least 2");
  end

  logic [NUM_IN-1:0] io_want;
  logic              byp_hit;
  logic [IDX_W-1:0]  byp_idx;
  logic              byp_ready;
  logic              rsp_byp;
  logic [IDX_W-1:0]  rsp_port;

  assign io_want = core_req_valid & core_req_io;

  always_comb begin
    byp_hit = 1'b0;
    byp_idx = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (io_want[i]) begin
        byp_hit = 1'b1;
        byp_idx = i[IDX_W-1:0];
      end
    end
  end

  assign byp_ready       = mem_req_ready & ~bank_req_valid;
  assign cache_req_valid = core_req_valid & ~core_req_io;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_port
    assign core_req_ready[g] = core_req_io[g]
      ? (byp_hit & byp_ready & (byp_idx == IDX_W'(g)))
      : cache_req_ready[g];
    assign core_rsp_valid[g] = mem_rsp_valid & rsp_byp & (rsp_port == IDX_W'(g));
  end

  assign mem_req_valid  = bank_req_valid | byp_hit;
  assign bank_req_ready = mem_req_ready;

  always_comb begin
    if (bank_req_valid) begin
      mem_req_write = bank_req_write;
      mem_req_addr  = bank_req_addr;
      mem_req_data  = bank_req_data;
      mem_req_tag   = {1'b0, BODY_W'(bank_req_tag)};
    end else begin
      mem_req_write = core_req_write[byp_idx];
      mem_req_addr  = core_req_addr[byp_idx*ADDR_W +: ADDR_W];
      mem_req_data  = core_req_data[byp_idx*DATA_W +: DATA_W];
      mem_req_tag   = {1'b1, BODY_W'({core_req_tag[byp_idx*CORE_TAG_W +: CORE_TAG_W], byp_idx})};
    end
  end

  assign rsp_byp        = mem_rsp_tag[MEM_TAG_W-1];
  assign rsp_port       = mem_rsp_tag[IDX_W-1:0];
  assign core_rsp_tag   = mem_rsp_tag[BYP_TAG_W-1:IDX_W];
  assign core_rsp_data  = mem_rsp_data;
  assign bank_rsp_valid = mem_rsp_valid & ~rsp_byp;
  assign bank_rsp_tag   = mem_rsp_tag[BANK_TAG_W-1:0];
  assign bank_rsp_data  = mem_rsp_data;
  assign mem_rsp_ready  = rsp_byp ? core_rsp_ready[rsp_port] : bank_rsp_ready;

  always_comb begin
    // R3
    bank_first_chk: assert (!(bank_req_valid && |(core_req_ready & io_want)));
    // R4
    one_io_grant_chk: assert ($onehot0(core_req_ready & io_want));
    // R8
    stall_chk: assert (mem_req_ready || !(|(core_req_ready & io_want)));
    // R9
    rsp_onehot_chk: assert ($onehot0(core_rsp_valid));
    // R7
    fill_excl_chk: assert (!(bank_rsp_valid && |core_rsp_valid));
    // R1
    cache_no_mem_chk: assert (|io_want || bank_req_valid || !mem_req_valid);
  end

endmodule

// File: tb/io_bypass_arbiter_tb_top.sv
module io_bypass_arbiter_tb_top;
  localparam int PERIOD = 10;
  localparam int N = 4, CT = 6, BT = 8, A = 16, D = 16, MT = 9;
  localparam int EW = 1 + A + D + MT;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic [N-1:0] core_req_valid, core_req_io, core_req_write, core_req_ready;
  logic [N*A-1:0] core_req_addr;
  logic [N*D-1:0] core_req_data;
  logic [N*CT-1:0] core_req_tag;
  logic [N-1:0] cache_req_valid, cache_req_ready;
  logic bank_req_valid, bank_req_write, bank_req_ready;
  logic [A-1:0] bank_req_addr, mem_req_addr;
  logic [D-1:0] bank_req_data, mem_req_data, mem_rsp_data, bank_rsp_data, core_rsp_data;
  logic [BT-1:0] bank_req_tag, bank_rsp_tag;
  logic mem_req_valid, mem_req_write, mem_req_ready;
  logic [MT-1:0] mem_req_tag, mem_rsp_tag;
  logic mem_rsp_valid, mem_rsp_ready, bank_rsp_valid, bank_rsp_ready;
  logic [N-1:0] core_rsp_valid, core_rsp_ready;
  logic [CT-1:0] core_rsp_tag;

  io_bypass_arbiter #(.NUM_IN(N), .CORE_TAG_W(CT), .BANK_TAG_W(BT), .ADDR_W(A), .DATA_W(D)) dut_i (
    .core_req_valid, .core_req_io, .core_req_write, .core_req_addr, .core_req_data,
    .core_req_tag, .core_req_ready, .cache_req_valid, .cache_req_ready,
    .bank_req_valid, .bank_req_write, .bank_req_addr, .bank_req_data, .bank_req_tag,
    .bank_req_ready, .mem_req_valid, .mem_req_write, .mem_req_addr, .mem_req_data,
    .mem_req_tag, .mem_req_ready, .mem_rsp_valid, .mem_rsp_data, .mem_rsp_tag,
    .mem_rsp_ready, .bank_rsp_valid, .bank_rsp_data, .bank_rsp_tag, .bank_rsp_ready,
    .core_rsp_valid, .core_rsp_data, .core_rsp_tag, .core_rsp_ready);

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [EW-1:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [MT-1:0] byp_tag(input logic [CT-1:0] t, input int p);
    return {1'b1, t, p[1:0]};
  endfunction

  task automatic push_exp(input bit w, input logic [A-1:0] a, input logic [D-1:0] d, input logic [MT-1:0] t);
    exp_q.push_back({w, a, d, t});
  endtask

  task automatic set_core(input int p, input bit io, input bit w, input logic [A-1:0] a,
                          input logic [D-1:0] d, input logic [CT-1:0] t);
    core_req_valid[p] = 1'b1;
    core_req_io[p] = io;
    core_req_write[p] = w;
    core_req_addr[p*A +: A] = a;
    core_req_data[p*D +: D] = d;
    core_req_tag[p*CT +: CT] = t;
  endtask

  task automatic idle_all();
    core_req_valid = '0; core_req_io = '0; core_req_write = '0;
    core_req_addr = '0; core_req_data = '0; core_req_tag = '0;
    cache_req_ready = '0; bank_req_valid = 1'b0; bank_req_write = 1'b0;
    bank_req_addr = '0; bank_req_data = '0; bank_req_tag = '0;
    mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_rsp_tag = '0;
    bank_rsp_ready = 1'b1; core_rsp_ready = '1;
  endtask

  // scoreboard monitor: pops on every completed memory request
  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R5 unexpected memory request", 64'(mem_req_tag), 64'h0);
      end else begin
        logic [EW-1:0] e;
        e = exp_q.pop_front();
        chk({mem_req_write, mem_req_addr, mem_req_data, mem_req_tag} == e, "R2/R5 memory request",
            64'({mem_req_write, mem_req_addr, mem_req_data, mem_req_tag}), 64'(e));
      end
    end
  end

  initial begin
    #(PERIOD * 10000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle_all();
    @(negedge clk); #1;
    chk(mem_req_valid == 1'b0, "R1 idle mem valid", 64'(mem_req_valid), 0);
    chk(core_rsp_valid == '0 && bank_rsp_valid == 1'b0, "R9 idle responses", 64'(core_rsp_valid), 0);

    // R1: cacheable request on port 1, with an I/O request on port 2 alongside (R2)
    @(negedge clk); idle_all();
    set_core(1, 0, 0, 16'h0100, 16'h0000, 6'h01);
    set_core(2, 1, 1, 16'h2200, 16'hA5A5, 6'h2A);
    cache_req_ready[1] = 1'b1;
    push_exp(1, 16'h2200, 16'hA5A5, byp_tag(6'h2A, 2));
    #1;
    chk(cache_req_valid == 4'b0010, "R1 cache valid", 64'(cache_req_valid), 64'h2);
    chk(core_req_ready == 4'b0110, "R1/R2 readies", 64'(core_req_ready), 64'h6);
    chk(mem_req_tag == 9'h1AA, "R2 tag layout", 64'(mem_req_tag), 64'h1AA);
    @(negedge clk); idle_all();
    set_core(1, 0, 0, 16'h0100, 16'h0000, 6'h01);
    #1;
    chk(core_req_ready[1] == 1'b0 && mem_req_valid == 1'b0, "R1 cache stall",
        64'({core_req_ready[1], mem_req_valid}), 0);

    // R3/R5: bank and bypass conflict
    @(negedge clk); idle_all();
    bank_req_valid = 1'b1; bank_req_write = 1'b1; bank_req_addr = 16'h1000;
    bank_req_data = 16'h1111; bank_req_tag = 8'h5C;
    set_core(3, 1, 0, 16'h3000, 16'h3333, 6'h11);
    push_exp(1, 16'h1000, 16'h1111, 9'h05C);
    #1;
    chk(core_req_ready[3] == 1'b0, "R3 bypass held", 64'(core_req_ready[3]), 0);
    chk(bank_req_ready == 1'b1, "R5 bank ready", 64'(bank_req_ready), 1);
    @(negedge clk); bank_req_valid = 1'b0;
    push_exp(0, 16'h3000, 16'h3333, byp_tag(6'h11, 3));
    #1;
    chk(core_req_ready[3] == 1'b1, "R3 bypass after bank", 64'(core_req_ready[3]), 1);

    // R4: two I/O ports, lowest wins
    @(negedge clk); idle_all();
    set_core(1, 1, 0, 16'h0110, 16'h0001, 6'h07);
    set_core(3, 1, 1, 16'h0330, 16'h0003, 6'h3F);
    push_exp(0, 16'h0110, 16'h0001, byp_tag(6'h07, 1));
    #1;
    chk(core_req_ready == 4'b0010, "R4 lowest port", 64'(core_req_ready), 64'h2);

    // R8: memory stalled
    @(negedge clk); idle_all();
    mem_req_ready = 1'b0;
    set_core(0, 1, 0, 16'h0AAA, 16'h0000, 6'h3C);
    #1;
    chk(core_req_ready[0] == 1'b0 && bank_req_ready == 1'b0, "R8 stall",
        64'({core_req_ready[0], bank_req_ready}), 0);
    chk(mem_req_valid == 1'b1 && mem_req_tag == byp_tag(6'h3C, 0), "R8 request held",
        64'(mem_req_tag), 64'(byp_tag(6'h3C, 0)));

    // R6: bypass response to port 3
    @(negedge clk); idle_all();
    mem_rsp_valid = 1'b1; mem_rsp_tag = 9'h157; mem_rsp_data = 16'hBEEF;
    #1;
    chk(core_rsp_valid == 4'b1000, "R6 steer", 64'(core_rsp_valid), 64'h8);
    chk(core_rsp_tag == 6'h15 && core_rsp_data == 16'hBEEF, "R6 tag/data",
        64'({core_rsp_tag, core_rsp_data}), 64'({6'h15, 16'hBEEF}));
    chk(bank_rsp_valid == 1'b0 && mem_rsp_ready == 1'b1, "R6 no fill",
        64'({bank_rsp_valid, mem_rsp_ready}), 64'h1);
    @(negedge clk); core_rsp_ready = 4'b0111;
    #1;
    chk(mem_rsp_ready == 1'b0, "R6 port backpressure", 64'(mem_rsp_ready), 0);

    // R7: fill response
    @(negedge clk); idle_all();
    mem_rsp_valid = 1'b1; mem_rsp_tag = 9'h0A3; mem_rsp_data = 16'h1234;
    #1;
    chk(bank_rsp_valid == 1'b1 && bank_rsp_tag == 8'hA3, "R7 fill", 64'(bank_rsp_tag), 64'hA3);
    chk(core_rsp_valid == '0, "R7 no core rsp", 64'(core_rsp_valid), 0);
    @(negedge clk); bank_rsp_ready = 1'b0;
    #1;
    chk(mem_rsp_ready == 1'b0, "R7 fill backpressure", 64'(mem_rsp_ready), 0);

    // R9: every port index
    for (int p = 0; p < N; p++) begin
      @(negedge clk); idle_all();
      mem_rsp_valid = 1'b1; mem_rsp_tag = byp_tag(6'(p + 9), p);
      #1;
      chk(core_rsp_valid == 4'(1 << p), "R9 single response", 64'(core_rsp_valid), 64'(1 << p));
    end

    @(negedge clk); idle_all();
    @(negedge clk);
    chk(exp_q.size() == 0, "R2 all requests seen", 64'(exp_q.size()), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule